// File: doc/BRIEF.md
# Bidirectional Dual-Port Universal Shift Register

This block is a storage register with two parallel data ports, A and B, a serial input and a serial output. A direction control decides which port feeds the register and which port drives it. Port A also has its own enable, so several of these registers can share one A-side bus. The block can move a word from one bus to the other in either direction. It can also gather serial bits and present them on either bus, take a word from either bus and shift it out serially, or hold a word. To recirculate a word, the serial output is tied back to the serial input outside the block.

Each bidirectional port is split into an input vector, an output vector and an output-enable, so the block can be synthesized. Parallel loads come in two kinds:

- **Clocked load:** the word is written on the rising clock edge.
- **Level-sensitive load:** the source port is passed straight through to the driven port in the same cycle, and the register is rewritten on every cycle of the fast system clock for as long as that mode is held.

Serial shifting is always clocked.

Top module: `dual_port_shreg`

## Requirements
- R1: A synchronous active-high reset clears the register to zero, and it has priority over every load and shift. While reset is high, the driven port shows the cleared register.
- R2: `b_oe` equals `dir_a2b`. `a_oe` is 1 only when `a_en` is 1 and `dir_a2b` is 0. The two enables are never 1 together.
- R3: With `par_mode`=1, `async_par`=0, `dir_a2b`=1 and `a_en`=1, the register takes `a_in` on a rising edge, and the word appears on `b_out` after that edge.
- R4: With `par_mode`=1, `async_par`=0 and `dir_a2b`=0, the register takes `b_in` on a rising edge, whatever the value of `a_en`. The word appears on `a_out` after that edge.
- R5: With `par_mode`=1, `dir_a2b`=1 and `a_en`=0, a parallel load leaves the register unchanged, in both the clocked and the level-sensitive kind.
- R6: With `par_mode`=1 and `async_par`=1, an enabled source port is visible on the driven port in the same cycle, with no clock edge needed. The register also holds the last such word, so it is kept after a switch to a non-loading mode.
- R7: With `par_mode`=0, each rising edge shifts the register one place from bit 0 toward bit 7, and `ser_in` enters bit 0. `ser_out` is bit 7 of the register.
- R8: With `par_mode`=0, `async_par` has no effect, so shifting stays clocked and gives the same result for either value of `async_par`.
- R9: When `ser_out` is fed back to `ser_in` for 8 shift edges, the stored word comes back unchanged. During those edges it appears on `ser_out` most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Lets port A take part in transfers |
| dir_a2b | input | 1 | 1: A is the source and B is driven; 0: B is the source and A is driven |
| async_par | input | 1 | 1: level-sensitive parallel load; 0: clocked parallel load |
| par_mode | input | 1 | 1: parallel load; 0: serial shift |
| ser_in | input | 1 | Serial data into bit 0 |
| a_in | input | 8 | Port A input side |
| b_in | input | 8 | Port B input side |
| a_out | output | 8 | Port A output side (register or pass-through word) |
| a_oe | output | 1 | Port A output enable |
| b_out | output | 8 | Port B output side (register or pass-through word) |
| b_oe | output | 1 | Port B output enable |
| ser_out | output | 1 | Serial output, bit 7 of the register |

## Verification
Two things can happen in the same cycle: the level-sensitive pass-through of a source port and the register write-back that the clock edge performs. The bench holds the level-sensitive mode, changes `a_in` between edges, and checks `b_out` with no edge in between. It then switches to a holding mode and checks that the register kept the last word passed through. Reset and a pending load also meet on the same edge: reset is raised while a clocked load is set up, and the result must be a cleared register.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;

    localparam int DPSR_W = 8;

    typedef enum logic [1:0] {
        M_SHIFT    = 2'd0,
        M_LOAD_CLK = 2'd1,
        M_LOAD_LVL = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  src_is_a;
        logic  load_ok;
    } ctrl_t;

    function automatic mode_e pick_mode(input logic par, input logic asy);
        if (!par)
            return M_SHIFT;
        else if (asy)
            return M_LOAD_LVL;
        else
            return M_LOAD_CLK;
    endfunction

    function automatic logic source_enabled(input logic src_is_a, input logic port_a_en);
        return src_is_a ? port_a_en : 1'b1;
    endfunction

endpackage

// File: rtl/dpsr_ctrl.sv
module dpsr_ctrl
    import dpsr_pkg::*;
#(
    parameter int W = DPSR_W
) (
    input  logic         par_mode,
    input  logic         async_par,
    input  logic         dir_a2b,
    input  logic         a_en,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output ctrl_t        ctrl,
    output logic [W-1:0] src_word
);

    always_comb begin
        ctrl.mode     = pick_mode(par_mode, async_par);
        ctrl.src_is_a = dir_a2b;
        ctrl.load_ok  = source_enabled(dir_a2b, a_en);
        src_word      = dir_a2b ? a_in : b_in;
    end

endmodule

// File: rtl/dpsr_core.sv
module dpsr_core
    import dpsr_pkg::*;
#(
    parameter int W = DPSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] src_word,
    input  logic         ser_in,
    output logic [W-1:0] state_q
);

    logic [W-1:0] shifted;
    logic [W-1:0] state_d;
    logic         do_load;

    assign shifted[0] = ser_in;

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_stage
            assign shifted[gi] = state_q[gi-1];
        end
    endgenerate

    always_comb begin
        do_load = (ctrl.mode != M_SHIFT) && ctrl.load_ok;
        state_d = state_q;
        if (ctrl.mode == M_SHIFT)
            state_d = shifted;
        else if (do_load)
            state_d = src_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/dpsr_ports.sv
module dpsr_ports
    import dpsr_pkg::*;
#(
    parameter int W = DPSR_W
) (
    input  logic         rst,
    input  logic         a_en,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] src_word,
    input  logic [W-1:0] state_q,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_out
);

    logic         live;
    logic [W-1:0] view;

    always_comb begin
        live    = !rst && (ctrl.mode == M_LOAD_LVL) && ctrl.load_ok;
        view    = live ? src_word : state_q;
        a_out   = view;
        b_out   = view;
        b_oe    = ctrl.src_is_a;
        a_oe    = a_en && !ctrl.src_is_a;
        ser_out = state_q[W-1];
    end

endmodule

// File: rtl/dual_port_shreg.sv
module dual_port_shreg
    import dpsr_pkg::*;
#(
    parameter int W = DPSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_en,
    input  logic         dir_a2b,
    input  logic         async_par,
    input  logic         par_mode,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_out
);

    ctrl_t        ctrl;
    logic [W-1:0] src_word;
    logic [W-1:0] state_q;

    dpsr_ctrl #(.W(W)) u_ctrl (
        .par_mode (par_mode),
        .async_par(async_par),
        .dir_a2b  (dir_a2b),
        .a_en     (a_en),
        .a_in     (a_in),
        .b_in     (b_in),
        .ctrl     (ctrl),
        .src_word (src_word)
    );

    dpsr_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .src_word(src_word),
        .ser_in  (ser_in),
        .state_q (state_q)
    );

    dpsr_ports #(.W(W)) u_ports (
        .rst     (rst),
        .a_en    (a_en),
        .ctrl    (ctrl),
        .src_word(src_word),
        .state_q (state_q),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .ser_out (ser_out)
    );

endmodule

// File: rtl/dpsr_checker.sv
module dpsr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         a_en,
    input logic         dir_a2b,
    input logic         async_par,
    input logic         par_mode,
    input logic         ser_in,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ser_out,
    input logic [W-1:0] state_q
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (state_q == '0));

    // R2
    a_r2_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_oe, b_oe}));
    a_r2_a_oe_gated: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> (a_en && !dir_a2b));

    // R3
    a_r3_load_from_a: assert property (@(posedge clk) disable iff (rst)
        (par_mode && dir_a2b && a_en) |=> (state_q == $past(a_in)));

    // R4
    a_r4_load_from_b: assert property (@(posedge clk) disable iff (rst)
        (par_mode && !dir_a2b) |=> (state_q == $past(b_in)));

    // R5
    a_r5_hold_when_a_off: assert property (@(posedge clk) disable iff (rst)
        (par_mode && dir_a2b && !a_en) |=> $stable(state_q));

    // R6
    a_r6_pass_a_to_b: assert property (@(posedge clk) disable iff (rst)
        (par_mode && async_par && dir_a2b && a_en) |-> (b_out == a_in));
    a_r6_pass_b_to_a: assert property (@(posedge clk) disable iff (rst)
        (par_mode && async_par && !dir_a2b) |-> (a_out == b_in));

    // R7 and R8 (shift independent of async_par)
    a_r7_shift_step: assert property (@(posedge clk) disable iff (rst)
        !par_mode |=> (state_q == {$past(state_q[W-2:0]), $past(ser_in)}));
    a_r7_ser_out_next: assert property (@(posedge clk) disable iff (rst)
        !par_mode |=> (ser_out == $past(state_q[W-2])));

endmodule

bind dual_port_shreg dpsr_checker #(.W(W)) u_dpsr_checker (
    .clk      (clk),
    .rst      (rst),
    .a_en     (a_en),
    .dir_a2b  (dir_a2b),
    .async_par(async_par),
    .par_mode (par_mode),
    .ser_in   (ser_in),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .ser_out  (ser_out),
    .state_q  (state_q)
);

// File: tb/test_dual_port_shreg.sv
module test_dual_port_shreg;

    localparam int W = 8;
    localparam int NV = 9;

    // stimulus: par, asy, dir, aen, ser, a, b ; expected register word
    typedef struct packed {
        logic         par;
        logic         asy;
        logic         dir;
        logic         aen;
        logic         ser;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hA5}, // R3
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h3C, 8'h3C}, // R4
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h3C}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'h79}, // R7
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hF2}, // R8
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'hE5}, // R8
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h00, 8'h5A}, // R6
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 8'hC3}, // R6
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81, 8'h81}  // R4
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a_en = 1'b0;
    logic         dir_a2b = 1'b0;
    logic         async_par = 1'b0;
    logic         par_mode = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
    logic         ser_out;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_port_shreg #(.W(W)) i_dual_port_shreg (
        .clk(clk), .rst(rst), .a_en(a_en), .dir_a2b(dir_a2b),
        .async_par(async_par), .par_mode(par_mode), .ser_in(ser_in),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic par, input logic asy, input logic dir,
                         input logic aen, input logic ser,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        par_mode = par; async_par = asy; dir_a2b = dir;
        a_en = aen; ser_in = ser; a_in = a; b_in = b;
    endtask

    function automatic logic [W-1:0] driven_port();
        return dir_a2b ? b_out : a_out;
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset with a clocked load set up; reset must win
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF);
        rst = 1'b1;
        step();
        step();
        check("R1 reset b_out", b_out, 8'h00);
        check("R1 reset ser_out", {7'd0, ser_out}, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step();
        rst = 1'b0;
        check("R1 reset after shift zeros", b_out, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].par, VECS[i].asy, VECS[i].dir, VECS[i].aen,
                  VECS[i].ser, VECS[i].a, VECS[i].b);
            step();
            check($sformatf("R3/R4/R5/R6/R7/R8 vec%0d word", i), driven_port(), VECS[i].exp);
            check($sformatf("R7 vec%0d ser_out", i), {7'd0, ser_out}, {7'd0, VECS[i].exp[W-1]});
            check($sformatf("R2 vec%0d b_oe", i), {7'd0, b_oe}, {7'd0, VECS[i].dir});
            check($sformatf("R2 vec%0d a_oe", i), {7'd0, a_oe},
                  {7'd0, VECS[i].aen & ~VECS[i].dir});
        end

        // R6: same-cycle pass-through, no clock edge between changes
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 8'h00);
        #0.5;
        check("R6 pass-through immediate", b_out, 8'h77);
        a_in = 8'h11;
        #0.5;
        check("R6 pass-through follows input", b_out, 8'h11);
        step();
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hEE, 8'h00);
        #0.5;
        check("R6 register kept last word", b_out, 8'h11);
        step();
        check("R5 clocked hold with a_en low", b_out, 8'h11);

        // R5: level-sensitive mode with port A disabled keeps register
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h99, 8'h00);
        #0.5;
        check("R5 level hold no edge", b_out, 8'h11);
        step();
        check("R5 level hold after edge", b_out, 8'h11);

        // R4: b-side load regardless of a_en, word read on a_out
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hB4);
        step();
        check("R4 load from b with a_en low", a_out, 8'hB4);

        // R9: recirculation, ser_out MSB first
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        for (int k = 0; k < W; k++) begin
            check($sformatf("R9 ser_out bit %0d", k), {7'd0, ser_out},
                  {7'd0, 1'(8'hB4 >> (W - 1 - k))});
            ser_in = ser_out;
            step();
        end
        check("R9 word restored", b_out, 8'hB4);

        // R1: reset clears a loaded register
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        step();
        check("R1 reset clears loaded word", b_out, 8'h00);
        rst = 1'b0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule